// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block decides, for a five-stage in-order integer pipeline, where each operand of the execute-stage ALU should come from. It looks at the two source register numbers of the instruction in execute. It compares them with the destination numbers and write-enable flags of the two younger results that have not yet reached the register file: the one held after execute (the memory-stage result) and the one held after memory (the writeback-stage result). For each operand it emits a 2-bit select and the selected 32-bit value. The value is chosen from the register-file read, the memory-stage result or the writeback-stage result.

A second pair of selects and values applies the same priority rules to the two compare registers of a branch resolved early in decode. A branch in decode can then use results from the 2nd and 3rd preceding ALU instructions without waiting for them to reach the register file. The parameter `BR_FWD` keeps or removes this decode-stage pair. The block is purely combinational: outputs follow the inputs within the same cycle, with no clock or state. The register file, the ALU, the comparator itself and the data memory sit outside it.

Top module: `fwd_unit`

## Requirements
- R1: A select encodes its source as 2'b00 = register-file value, 2'b10 = memory-stage result, 2'b01 = writeback-stage result. Each data output equals the source that its select names.
- R2: An operand takes the memory-stage result only when `mem_we` is 1, `mem_rd` is nonzero and `mem_rd` equals that operand's source register number.
- R3: An operand takes the writeback-stage result only when `wb_we` is 1, `wb_rd` is nonzero, `wb_rd` equals the operand's source register number, and R2's condition does not hold for that operand.
- R4: When both stages write the operand's source register, the memory-stage result wins, so the newest value reaches the operand.
- R5: A source register number of 0 always selects the register file (2'b00), whatever either stage writes.
- R6: Operand A (from `ex_rs`) and operand B (from `ex_rt`) are resolved independently. Each may pick a different source in the same cycle.
- R7: The decode-stage branch outputs `br_sel_a`/`br_a` (from `id_rs`) and `br_sel_b`/`br_b` (from `id_rt`) obey R1 to R5 against the same two stages.
- R8: The code 2'b11 never appears on any select.
- R9: Outputs react to an input change within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | 5 | First source register number of the execute-stage instruction |
| ex_rt | input | 5 | Second source register number of the execute-stage instruction |
| ex_rf_a | input | 32 | Register-file value read for operand A |
| ex_rf_b | input | 32 | Register-file value read for operand B |
| id_rs | input | 5 | First compare register number of the decode-stage branch |
| id_rt | input | 5 | Second compare register number of the decode-stage branch |
| id_rf_a | input | 32 | Register-file value for the first compare register |
| id_rf_b | input | 32 | Register-file value for the second compare register |
| mem_rd | input | 5 | Destination register number held after execute |
| mem_we | input | 1 | Register-write flag held after execute |
| mem_res | input | 32 | Result held after execute |
| wb_rd | input | 5 | Destination register number held after memory |
| wb_we | input | 1 | Register-write flag held after memory |
| wb_res | input | 32 | Result held after memory |
| alu_sel_a | output | 2 | Source select for ALU operand A |
| alu_sel_b | output | 2 | Source select for ALU operand B |
| alu_a | output | 32 | Selected ALU operand A |
| alu_b | output | 32 | Selected ALU operand B |
| br_sel_a | output | 2 | Source select for the first branch compare value |
| br_sel_b | output | 2 | Source select for the second branch compare value |
| br_a | output | 32 | Selected first branch compare value |
| br_b | output | 32 | Selected second branch compare value |

## Verification
On every evaluation, the assertions check several properties. No select ever shows 2'b11. Each memory-stage or writeback-stage select is justified by a live, nonzero, matching destination. A live match in the memory stage always wins over the writeback stage. A zero source never forwards. Each data output agrees with its select. Only the bench's scenarios can show the remaining properties. These are that a back-to-back write pair to one register delivers the newer result, that operands A and B and the two branch operands each pick different sources in one vector, and that outputs follow an input change twice within a single cycle.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int RW     = 5,
  parameter int DW     = 32,
  parameter bit BR_FWD = 1'b1
) (
  input  logic [RW-1:0] ex_rs,
  input  logic [RW-1:0] ex_rt,
  input  logic [DW-1:0] ex_rf_a,
  input  logic [DW-1:0] ex_rf_b,
  input  logic [RW-1:0] id_rs,
  input  logic [RW-1:0] id_rt,
  input  logic [DW-1:0] id_rf_a,
  input  logic [DW-1:0] id_rf_b,
  input  logic [RW-1:0] mem_rd,
  input  logic          mem_we,
  input  logic [DW-1:0] mem_res,
  input  logic [RW-1:0] wb_rd,
  input  logic          wb_we,
  input  logic [DW-1:0] wb_res,
  output logic [1:0]    alu_sel_a,
  output logic [1:0]    alu_sel_b,
  output logic [DW-1:0] alu_a,
  output logic [DW-1:0] alu_b,
  output logic [1:0]    br_sel_a,
  output logic [1:0]    br_sel_b,
  output logic [DW-1:0] br_a,
  output logic [DW-1:0] br_b
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam int         NCH     = 4;

  logic [RW-1:0] src [NCH];
  logic [DW-1:0] rfv [NCH];
  logic [1:0]    sel [NCH];
  logic [DW-1:0] val [NCH];

  assign src[0] = ex_rs;   assign rfv[0] = ex_rf_a;
  assign src[1] = ex_rt;   assign rfv[1] = ex_rf_b;
  assign src[2] = id_rs;   assign rfv[2] = id_rf_a;
  assign src[3] = id_rt;   assign rfv[3] = id_rf_b;

  wire mem_live = mem_we && (mem_rd != '0);
  wire wb_live  = wb_we  && (wb_rd  != '0);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    if (g < 2 || BR_FWD) begin : g_fwd
      logic hit_m, hit_w;
      assign hit_m  = mem_live && (mem_rd == src[g]);
      assign hit_w  = wb_live  && (wb_rd  == src[g]) && !hit_m;
      assign sel[g] = hit_m ? SEL_MEM : (hit_w ? SEL_WB : SEL_RF);
    end else begin : g_off
      assign sel[g] = SEL_RF;
    end

    always_comb begin
      case (sel[g])
        SEL_MEM: val[g] = mem_res;
        SEL_WB:  val[g] = wb_res;
        default: val[g] = rfv[g];
      endcase
    end
  end

  assign alu_sel_a = sel[0];
  assign alu_sel_b = sel[1];
  assign br_sel_a  = sel[2];
  assign br_sel_b  = sel[3];
  assign alu_a     = val[0];
  assign alu_b     = val[1];
  assign br_a      = val[2];
  assign br_b      = val[3];
endmodule

module fwd_unit_chk #(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input logic [RW-1:0] ex_rs,
  input logic [RW-1:0] ex_rt,
  input logic [DW-1:0] ex_rf_a,
  input logic [DW-1:0] ex_rf_b,
  input logic [RW-1:0] id_rs,
  input logic [RW-1:0] id_rt,
  input logic [DW-1:0] id_rf_a,
  input logic [DW-1:0] id_rf_b,
  input logic [RW-1:0] mem_rd,
  input logic          mem_we,
  input logic [DW-1:0] mem_res,
  input logic [RW-1:0] wb_rd,
  input logic          wb_we,
  input logic [DW-1:0] wb_res,
  input logic [1:0]    alu_sel_a,
  input logic [1:0]    alu_sel_b,
  input logic [DW-1:0] alu_a,
  input logic [DW-1:0] alu_b,
  input logic [1:0]    br_sel_a,
  input logic [1:0]    br_sel_b,
  input logic [DW-1:0] br_a,
  input logic [DW-1:0] br_b
);
  always_comb begin
    assert_sel_legal_R8: assert (alu_sel_a != 2'b11 && alu_sel_b != 2'b11 &&
                                 br_sel_a != 2'b11 && br_sel_b != 2'b11)
      else $error("select code 11 seen");
    assert_mem_cause_a_R2: assert (alu_sel_a != 2'b10 || (mem_we && mem_rd != '0 && mem_rd == ex_rs))
      else $error("operand A memory forward without cause");
    assert_mem_cause_b_R2: assert (alu_sel_b != 2'b10 || (mem_we && mem_rd != '0 && mem_rd == ex_rt))
      else $error("operand B memory forward without cause");
    assert_wb_cause_a_R3: assert (alu_sel_a != 2'b01 || (wb_we && wb_rd != '0 && wb_rd == ex_rs))
      else $error("operand A writeback forward without cause");
    assert_wb_cause_b_R3: assert (alu_sel_b != 2'b01 || (wb_we && wb_rd != '0 && wb_rd == ex_rt))
      else $error("operand B writeback forward without cause");
    assert_mem_wins_a_R4: assert (!(mem_we && mem_rd != '0 && mem_rd == ex_rs) || alu_sel_a == 2'b10)
      else $error("operand A lost memory-stage priority");
    assert_mem_wins_b_R4: assert (!(mem_we && mem_rd != '0 && mem_rd == ex_rt) || alu_sel_b == 2'b10)
      else $error("operand B lost memory-stage priority");
    assert_zero_src_R5: assert ((ex_rs != '0 || alu_sel_a == 2'b00) && (ex_rt != '0 || alu_sel_b == 2'b00))
      else $error("register zero forwarded");
    assert_data_a_R1: assert ((alu_sel_a == 2'b00 && alu_a == ex_rf_a) ||
                              (alu_sel_a == 2'b10 && alu_a == mem_res) ||
                              (alu_sel_a == 2'b01 && alu_a == wb_res))
      else $error("operand A data disagrees with select");
    assert_data_b_R1: assert ((alu_sel_b == 2'b00 && alu_b == ex_rf_b) ||
                              (alu_sel_b == 2'b10 && alu_b == mem_res) ||
                              (alu_sel_b == 2'b01 && alu_b == wb_res))
      else $error("operand B data disagrees with select");
    assert_br_data_R7: assert (((br_sel_a == 2'b00 && br_a == id_rf_a) ||
                                (br_sel_a == 2'b10 && br_a == mem_res) ||
                                (br_sel_a == 2'b01 && br_a == wb_res)) &&
                               ((br_sel_b == 2'b00 && br_b == id_rf_b) ||
                                (br_sel_b == 2'b10 && br_b == mem_res) ||
                                (br_sel_b == 2'b01 && br_b == wb_res)))
      else $error("branch data disagrees with select");
    assert_br_zero_R7: assert ((id_rs != '0 || br_sel_a == 2'b00) && (id_rt != '0 || br_sel_b == 2'b00))
      else $error("branch register zero forwarded");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.RW(RW), .DW(DW)) u_chk (.*);

// File: tb/sim_fwd_unit.sv
`timescale 1ns/1ps
module sim_fwd_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0]  ex_rs, ex_rt, id_rs, id_rt, mem_rd, wb_rd;
  logic        mem_we, wb_we;
  logic [31:0] ex_rf_a, ex_rf_b, id_rf_a, id_rf_b, mem_res, wb_res;
  logic [1:0]  alu_sel_a, alu_sel_b, br_sel_a, br_sel_b;
  logic [31:0] alu_a, alu_b, br_a, br_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  fwd_unit u0 (
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rf_a(ex_rf_a), .ex_rf_b(ex_rf_b),
    .id_rs(id_rs), .id_rt(id_rt), .id_rf_a(id_rf_a), .id_rf_b(id_rf_b),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_res(mem_res),
    .wb_rd(wb_rd), .wb_we(wb_we), .wb_res(wb_res),
    .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .alu_a(alu_a), .alu_b(alu_b),
    .br_sel_a(br_sel_a), .br_sel_b(br_sel_b), .br_a(br_a), .br_b(br_b)
  );

  function automatic logic [1:0] want_sel(logic [4:0] s);
    if (mem_we && mem_rd != 5'd0 && mem_rd == s) return 2'b10;
    if (wb_we && wb_rd != 5'd0 && wb_rd == s)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] want_val(logic [1:0] sl, logic [31:0] rf);
    return (sl == 2'b10) ? mem_res : ((sl == 2'b01) ? wb_res : rf);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk(req, {30'd0, alu_sel_a}, {30'd0, want_sel(ex_rs)});
    chk(req, {30'd0, alu_sel_b}, {30'd0, want_sel(ex_rt)});
    chk(req, alu_a, want_val(want_sel(ex_rs), ex_rf_a));
    chk(req, alu_b, want_val(want_sel(ex_rt), ex_rf_b));
    chk(req, {30'd0, br_sel_a}, {30'd0, want_sel(id_rs)});
    chk(req, {30'd0, br_sel_b}, {30'd0, want_sel(id_rt)});
    chk(req, br_a, want_val(want_sel(id_rs), id_rf_a));
    chk(req, br_b, want_val(want_sel(id_rt), id_rf_b));
  endtask

  task automatic setv(logic [4:0] ers, logic [4:0] ert, logic [4:0] irs, logic [4:0] irt,
                      logic [4:0] mrd, logic mwe, logic [4:0] wrd, logic wwe);
    @(posedge clk);
    #1;
    ex_rs = ers; ex_rt = ert; id_rs = irs; id_rt = irt;
    mem_rd = mrd; mem_we = mwe; wb_rd = wrd; wb_we = wwe;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2718));
    ex_rs = 0; ex_rt = 0; id_rs = 0; id_rt = 0; mem_rd = 0; wb_rd = 0;
    mem_we = 0; wb_we = 0;
    ex_rf_a = 32'h1111_0001; ex_rf_b = 32'h2222_0002;
    id_rf_a = 32'h3333_0003; id_rf_b = 32'h4444_0004;
    mem_res = 32'hAAAA_00E0; wb_res = 32'hBBBB_00B0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 idle sel a", {30'd0, alu_sel_a}, 32'd0);
    chk("R1 idle data a", alu_a, 32'h1111_0001);
    chk("R1 idle data b", alu_b, 32'h2222_0002);

    setv(5'd3, 5'd4, 5'd0, 5'd0, 5'd3, 1'b1, 5'd0, 1'b0);
    chk("R2 mem fwd sel", {30'd0, alu_sel_a}, 32'd2);
    chk("R2 mem fwd data", alu_a, 32'hAAAA_00E0);
    chk("R6 other operand untouched", alu_b, 32'h2222_0002);
    setv(5'd3, 5'd4, 5'd0, 5'd0, 5'd3, 1'b0, 5'd0, 1'b0);
    chk("R2 no write no fwd", {30'd0, alu_sel_a}, 32'd0);
    setv(5'd3, 5'd7, 5'd0, 5'd0, 5'd0, 1'b0, 5'd7, 1'b1);
    chk("R3 wb fwd sel", {30'd0, alu_sel_b}, 32'd1);
    chk("R3 wb fwd data", alu_b, 32'hBBBB_00B0);
    setv(5'd3, 5'd7, 5'd0, 5'd0, 5'd0, 1'b0, 5'd7, 1'b0);
    chk("R3 no write no fwd", alu_b, 32'h2222_0002);
    setv(5'd9, 5'd9, 5'd0, 5'd0, 5'd9, 1'b1, 5'd9, 1'b1);
    chk("R4 newest wins a", alu_a, 32'hAAAA_00E0);
    chk("R4 newest wins b", {30'd0, alu_sel_b}, 32'd2);
    setv(5'd9, 5'd9, 5'd0, 5'd0, 5'd9, 1'b0, 5'd9, 1'b1);
    chk("R4 older used when newer silent", alu_a, 32'hBBBB_00B0);
    setv(5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
    chk("R5 zero reg a", alu_a, 32'h1111_0001);
    chk("R5 zero reg b", {30'd0, alu_sel_b}, 32'd0);
    chk("R5 zero reg branch", br_a, 32'h3333_0003);
    setv(5'd5, 5'd6, 5'd0, 5'd0, 5'd5, 1'b1, 5'd6, 1'b1);
    chk("R6 a from mem", alu_a, 32'hAAAA_00E0);
    chk("R6 b from wb", alu_b, 32'hBBBB_00B0);
    setv(5'd0, 5'd0, 5'd12, 5'd13, 5'd13, 1'b1, 5'd12, 1'b1);
    chk("R7 branch a from wb", {30'd0, br_sel_a}, 32'd1);
    chk("R7 branch b from mem", br_b, 32'hAAAA_00E0);
    setv(5'd0, 5'd0, 5'd12, 5'd12, 5'd12, 1'b1, 5'd12, 1'b1);
    chk("R7 branch priority", br_a, 32'hAAAA_00E0);
    chk_all("R7 branch full");

    @(posedge clk);
    #1;
    ex_rs = 5'd8; mem_rd = 5'd8; mem_we = 1'b1; wb_we = 1'b0;
    #0.5;
    chk("R9 same-cycle follow 1", alu_a, 32'hAAAA_00E0);
    mem_we = 1'b0;
    #0.5;
    chk("R9 same-cycle follow 2", alu_a, 32'h1111_0001);
    @(negedge clk);

    for (int i = 0; i < 1500; i++) begin
      @(posedge clk);
      #1;
      ex_rs = 5'($urandom_range(0, 3)); ex_rt = 5'($urandom_range(0, 3));
      id_rs = 5'($urandom_range(0, 3)); id_rt = 5'($urandom_range(0, 3));
      mem_rd = 5'($urandom_range(0, 3)); wb_rd = 5'($urandom_range(0, 3));
      mem_we = 1'($urandom); wb_we = 1'($urandom);
      ex_rf_a = $urandom; ex_rf_b = $urandom; id_rf_a = $urandom; id_rf_b = $urandom;
      mem_res = $urandom; wb_res = $urandom;
      @(negedge clk);
      chk_all("R1 R2 R3 R4 R5 R6 random");
      chk("R8 no code 11", {31'd0, (alu_sel_a == 2'b11) || (alu_sel_b == 2'b11) ||
                                    (br_sel_a == 2'b11) || (br_sel_b == 2'b11)}, 32'd0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule